// File: doc/BRIEF.md
# Hardwired Token-Pulse Sequencer

This block sequences a fixed control flow by passing one token pulse through chains of D flip-flops instead of holding an encoded state. A level start request is cut down to a single one-cycle pulse. That pulse walks down a prelude chain, and each stage of the chain raises one control line for one clock period. At the end of the prelude a steering element reads a status bit and sends the pulse down one of two alternative chains. The two chains then merge, and a fork copies the pulse onto three parallel branch chains of different lengths. A three-input join holds each branch's arrival in a sticky flag. It raises a one-cycle end pulse once all three branches have arrived.

The outputs drive the enables of a datapath. Bit `ctl_o[i]` is the control line of one step. `end_o` marks completion. A new start edge is taken only when no token is in flight.

Top module: `pulse_seq_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycles after it until a start is accepted, every bit of `ctl_o` and `end_o` is 0, and all join flags are clear.
- R2: A start edge is accepted when `start_i` is sampled high at an edge after being sampled low at the previous edge, and the network is idle. After an accepted edge, `ctl_o[0]` is high for exactly the one clock period that follows. If `start_i` stays high, no further pulse is produced.
- R3: Counting the period of `ctl_o[0]` as period 0, prelude bit `ctl_o[k]` (k = 1..3 at defaults) is high in period k only.
- R4: `status_i` is sampled at the edge that ends period 3. A value of 1 routes the token through path A, bits 4..5, which are high in periods 4 and 5. A value of 0 routes it through path B, bits 6..9, which are high in periods 4..7. Exactly one path receives the token.
- R5: `status_i` has no effect in any cycle other than the sampling edge of R4.
- R6: In the period after the last stage of the taken path, the token appears in the first stage of all three branches at once. The branches are bits 10..11, 12..15 and 16..18. Their first stages are high in period 6 after path A and in period 8 after path B, and each later stage follows one period after the stage before it.
- R7: `end_o` is high for one period. It rises in the period after the last branch's final stage, and only after all three branches have arrived, whatever their order. At defaults this is period 10 after path A and period 12 after path B. The join flags clear at the end of that period.
- R8: A start edge that is sampled while any stage or join flag is set is ignored, and this includes an edge sampled at the end of the `end_o` period. An edge sampled one period later is accepted.
- R9: In any cycle, at most one control line is high in the prelude, in each alternative path and in each branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Level start request |
| status_i | input | 1 | Status bit read by the steering element |
| ctl_o | output | 19 | Per-step control lines (bit map in R2..R6) |
| end_o | output | 1 | Completion pulse from the join |

## Verification
The end pulse of one run and the start edge of the next run can fall in the same cycle. The block therefore has to decide whether the join's last period still counts as busy. The bench raises `start_i` so that it is first sampled at the edge that ends the `end_o` period, and expects no new run. It then raises `start_i` one period later and expects a run whose period 0 follows that edge directly. Both traces are compared cycle by cycle against a scoreboard built from the timing in the requirements.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;
  localparam int unsigned NUM_BRANCH = 3;

  // Length of branch j, picked from the three branch parameters
  function automatic int unsigned pick_len(input int unsigned j, input int unsigned l0,
                                           input int unsigned l1, input int unsigned l2);
    return (j == 0) ? l0 : ((j == 1) ? l1 : l2);
  endfunction

  // Bit offset of branch j inside the branch field
  function automatic int unsigned pick_off(input int unsigned j, input int unsigned l0,
                                           input int unsigned l1);
    return (j == 0) ? 0 : ((j == 1) ? l0 : l0 + l1);
  endfunction
endpackage

// File: rtl/pulse_oneshot.sv
module pulse_oneshot (
  input  logic clk,
  input  logic rst_ni,
  input  logic start_i,
  input  logic busy_i,
  output logic pulse_o
);
  logic seen_q, seen_d;
  logic pulse_q, pulse_d;

  always_comb begin
    seen_d  = start_i;
    pulse_d = start_i & ~seen_q & ~busy_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      seen_q  <= seen_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  assert_one_wide_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_i |=> !pulse_q);
endmodule

// File: rtl/pulse_chain.sv
module pulse_chain #(
  parameter int unsigned LEN = 3
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           pulse_i,
  output logic [LEN-1:0] stage_o
);
  logic [LEN-1:0] stg_q, stg_d;
  logic           adv_en;

  generate
    if (LEN == 1) begin : g_single
      always_comb stg_d = pulse_i;
    end else begin : g_multi
      always_comb stg_d = {stg_q[LEN-2:0], pulse_i};
    end
  endgenerate

  assign adv_en = pulse_i | (|stg_q);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else if (adv_en) stg_q <= stg_d;
  end

  assign stage_o = stg_q;

  assert_path_single_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(stg_q));

  generate
    for (genvar k = 0; k + 1 < LEN; k++) begin : g_shift_chk
      assert_step_delay_R3: assert property (@(posedge clk) disable iff (!rst_ni)
        stg_q[k] |=> stg_q[k+1]);
    end
  endgenerate
endmodule

// File: rtl/pulse_steer.sv
module pulse_steer (
  input  logic pulse_i,
  input  logic status_i,
  output logic take_a_o,
  output logic take_b_o
);
  always_comb begin
    take_a_o = pulse_i & status_i;
    take_b_o = pulse_i & ~status_i;
  end
endmodule

// File: rtl/pulse_join.sv
module pulse_join #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] arrive_i,
  output logic         fire_o,
  output logic         busy_o
);
  logic [N-1:0] flg_q, flg_d;
  logic         all_set;
  logic         upd_en;

  always_comb begin
    all_set = &flg_q;
    flg_d   = all_set ? '0 : (flg_q | arrive_i);
    upd_en  = all_set | (|arrive_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else if (upd_en) flg_q <= flg_d;
  end

  assign fire_o = all_set;
  assign busy_o = |flg_q;

  assert_join_clear_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    fire_o |=> (flg_q == '0));

  generate
    for (genvar j = 0; j < N; j++) begin : g_flag_chk
      assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(flg_q[j]) |-> $past(arrive_i[j]));
      assert_no_double_R9: assert property (@(posedge clk) disable iff (!rst_ni)
        arrive_i[j] |-> !flg_q[j]);
    end
  endgenerate
endmodule

// File: rtl/pulse_seq_ctrl.sv
module pulse_seq_ctrl
  import pulse_seq_pkg::*;
#(
  parameter int unsigned PRE_LEN   = 3,
  parameter int unsigned PATHA_LEN = 2,
  parameter int unsigned PATHB_LEN = 4,
  parameter int unsigned BR0_LEN   = 2,
  parameter int unsigned BR1_LEN   = 4,
  parameter int unsigned BR2_LEN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic status_i,
  output logic [PRE_LEN+PATHA_LEN+PATHB_LEN+BR0_LEN+BR1_LEN+BR2_LEN:0] ctl_o,
  output logic end_o
);
  localparam int unsigned A_OFF  = 1 + PRE_LEN;
  localparam int unsigned B_OFF  = A_OFF + PATHA_LEN;
  localparam int unsigned BR_OFF = B_OFF + PATHB_LEN;

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                 sp;
  logic [PRE_LEN-1:0]   pre_stg;
  logic [PATHA_LEN-1:0] a_stg;
  logic [PATHB_LEN-1:0] b_stg;
  logic                 take_a, take_b, merged;
  logic [NUM_BRANCH-1:0] br_first, br_last;
  logic                 join_busy, busy;

  assign busy = (|ctl_o) | join_busy;

  pulse_oneshot u_shot (
    .clk(clk), .rst_ni(rst_core_n), .start_i(start_i), .busy_i(busy), .pulse_o(sp)
  );

  pulse_chain #(.LEN(PRE_LEN)) u_pre (
    .clk(clk), .rst_ni(rst_core_n), .pulse_i(sp), .stage_o(pre_stg)
  );

  pulse_steer u_steer (
    .pulse_i(pre_stg[PRE_LEN-1]), .status_i(status_i), .take_a_o(take_a), .take_b_o(take_b)
  );

  pulse_chain #(.LEN(PATHA_LEN)) u_path_a (
    .clk(clk), .rst_ni(rst_core_n), .pulse_i(take_a), .stage_o(a_stg)
  );

  pulse_chain #(.LEN(PATHB_LEN)) u_path_b (
    .clk(clk), .rst_ni(rst_core_n), .pulse_i(take_b), .stage_o(b_stg)
  );

  assign merged = a_stg[PATHA_LEN-1] | b_stg[PATHB_LEN-1];

  assign ctl_o[0]               = sp;
  assign ctl_o[A_OFF-1:1]       = pre_stg;
  assign ctl_o[B_OFF-1:A_OFF]   = a_stg;
  assign ctl_o[BR_OFF-1:B_OFF]  = b_stg;

  generate
    for (genvar j = 0; j < NUM_BRANCH; j++) begin : g_branch
      localparam int unsigned L   = pick_len(j, BR0_LEN, BR1_LEN, BR2_LEN);
      localparam int unsigned OFF = BR_OFF + pick_off(j, BR0_LEN, BR1_LEN);
      logic [L-1:0] stg;

      pulse_chain #(.LEN(L)) u_br (
        .clk(clk), .rst_ni(rst_core_n), .pulse_i(merged), .stage_o(stg)
      );

      assign ctl_o[OFF+L-1:OFF] = stg;
      assign br_first[j]        = stg[0];
      assign br_last[j]         = stg[L-1];
    end
  endgenerate

  pulse_join #(.N(NUM_BRANCH)) u_join (
    .clk(clk), .rst_ni(rst_core_n), .arrive_i(br_last), .fire_o(end_o), .busy_o(join_busy)
  );

  assert_steer_one_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    pre_stg[PRE_LEN-1] |=> ($countones({a_stg[0], b_stg[0]}) == 1));
  assert_fork_all_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    merged |=> (br_first == '1));
  assert_end_single_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    end_o |=> !end_o);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_core_n |-> (ctl_o == '0 && !end_o));
endmodule

// File: tb/pulse_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pulse_seq_ctrl_tb_top;
  localparam int PRE = 3, LA = 2, LB = 4, L0 = 2, L1 = 4, L2 = 3;
  localparam int NC  = 1 + PRE + LA + LB + L0 + L1 + L2;
  localparam int A_B = 1 + PRE, B_B = A_B + LA, R0_B = B_B + LB;
  localparam int R1_B = R0_B + L0, R2_B = R1_B + L1;
  localparam int MAXL = (L0 > L1) ? ((L0 > L2) ? L0 : L2) : ((L1 > L2) ? L1 : L2);

  logic clk = 1'b0;
  logic rst_n, start_i, status_i;
  logic [NC-1:0] ctl_o;
  logic end_o;

  int n_chk = 0, n_fail = 0;
  string cur_test = "R1";
  logic [NC:0] exp_q[$];
  bit mon_on = 0;

  // bench tracker of the expected run (from the requirements)
  int run_p = -1;
  bit run_a = 1'b1;
  bit prev_start = 1'b0;

  always #2.5 clk = ~clk;

  pulse_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_i(status_i),
    .ctl_o(ctl_o), .end_o(end_o)
  );

  function automatic int end_period(bit a);
    return PRE + (a ? LA : LB) + 1 + MAXL;
  endfunction

  function automatic logic [NC:0] exp_vec(int p, bit a);
    logic [NC:0] v = '0;
    int dlen = a ? LA : LB;
    int dbase = a ? A_B : B_B;
    int m = PRE + dlen + 1;
    if (p < 0) return v;
    if (p <= PRE) v[p] = 1'b1;                                   // R2, R3
    if (p > PRE && p <= PRE + dlen) v[dbase + p - PRE - 1] = 1'b1; // R4
    if (p >= m && p < m + L0) v[R0_B + p - m] = 1'b1;            // R6
    if (p >= m && p < m + L1) v[R1_B + p - m] = 1'b1;
    if (p >= m && p < m + L2) v[R2_B + p - m] = 1'b1;
    if (p == m + MAXL) v[NC] = 1'b1;                             // R7
    return v;
  endfunction

  function automatic string req_of(logic [NC:0] d);
    for (int i = 0; i <= NC; i++) begin
      if (d[i]) begin
        if (i == 0) return "R2";
        if (i < A_B) return "R3";
        if (i < R0_B) return "R4";
        if (i < NC) return "R6";
        return "R7";
      end
    end
    return "R1";
  endfunction

  // driver: set inputs for this period and push the expected value of the next one
  task automatic tick(input bit s, input bit st);
    @(negedge clk);
    start_i  = s;
    status_i = st;
    if (run_p == PRE) run_a = st;
    if (s && !prev_start && run_p < 0) run_p = 0;              // R8: idle only
    else if (run_p >= 0) run_p = (run_p >= end_period(run_a)) ? -1 : run_p + 1;
    prev_start = s;
    exp_q.push_back(exp_vec(run_p, run_a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && exp_q.size() > 0) begin
        logic [NC:0] e, a;
        e = exp_q.pop_front();
        a = {end_o, ctl_o};
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s (test %s) actual=%b expected=%b", req_of(a ^ e), cur_test, a, e);
        end
        n_chk++;  // R9: one line per path
        if ($countones(ctl_o[PRE:1]) > 1 || $countones(ctl_o[B_B-1:A_B]) > 1 ||
            $countones(ctl_o[R0_B-1:B_B]) > 1 || $countones(ctl_o[R1_B-1:R0_B]) > 1 ||
            $countones(ctl_o[R2_B-1:R1_B]) > 1 || $countones(ctl_o[NC-1:R2_B]) > 1) begin
          n_fail++;
          $display("FAIL R9 actual=%b expected=at most one per path", ctl_o);
        end
      end
    end
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; status_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;                                                     // R1
    if (ctl_o !== '0 || end_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 actual=%b expected=0", {end_o, ctl_o});
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1;
    cur_test = "R1"; idle(4);

    cur_test = "R4"; tick(1, 1); tick(0, 1);                     // path A
    for (int i = 0; i < 14; i++) tick(0, 1);
    cur_test = "R4"; tick(1, 0);                                 // path B
    for (int i = 0; i < 16; i++) tick(0, 0);

    cur_test = "R5"; tick(1, 0);                                 // status 1 except sample edge
    for (int i = 0; i < 16; i++) tick(0, (run_p == PRE) ? 1'b0 : 1'b1);
    cur_test = "R5"; tick(1, 1);                                 // status 0 except sample edge
    for (int i = 0; i < 14; i++) tick(0, (run_p == PRE) ? 1'b1 : 1'b0);

    cur_test = "R8"; tick(1, 1);                                 // held, dropped, re-raised while busy
    for (int i = 0; i < 4; i++) tick(1, 1);
    tick(0, 1); tick(0, 1);
    for (int i = 0; i < 12; i++) tick(1, 1);                     // R2: held high, no second pulse
    idle(3);

    cur_test = "R8"; tick(1, 0);                                 // edge at end of end_o period
    while (run_p != end_period(run_a)) tick(0, 0);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    cur_test = "R7"; tick(1, 1);                                 // back-to-back acceptance
    while (run_p != end_period(run_a)) tick(0, 1);
    tick(0, 1);
    tick(1, 1);
    for (int i = 0; i < 14; i++) tick(0, 1);
    idle(3);

    @(posedge clk); #2;
    mon_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule